// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Latched Test Mode

This block is a synchronous, cycle-level model of the device side of an asynchronous-strobe DRAM. A fast clock samples the row strobe, the column strobe, the write enable, the multiplexed address pins and the write data. The block finds strobe edges by comparing each registered sample with the one before it. The cycle type follows only from the order of those edges. The block refreshes rows, serves reads, early writes and read-modify-writes from a small array of 4-bit words, and keeps a test-mode flag that stays set from one access to the next.

There are three refresh flavours. A column strobe that is already low when the row strobe falls starts a counter-driven refresh. If write enable is also low at that moment, the refresh also switches test mode on. A row strobe that opens and closes without any column strobe refreshes the row on the address pins. Either kind of refresh with write enable high switches test mode off. In test mode the two lowest column bits do not take part: a write goes to a group of four words, and a read returns, for each data bit, whether all four stored copies agree. That compare result arrives one clock later than a normal read.

Each classified cycle is reported by a one-clock strobe that comes with a type code and the row it touched.

Top module: `strobe_cycle_decoder`

## Requirements
- R1: After reset, dout_en, cyc_stb and test_mode are 0 and the refresh row counter is 0.
- R2: A row-strobe fall while the column strobe is already low and write enable is high reports code 5. cyc_row carries the counter value, the counter then increments and test_mode clears. The report appears two clocks after the row-strobe pin change.
- R3: A row-strobe fall with the column strobe high, followed by a row-strobe rise with no column strobe in between, reports code 4 at the rise. cyc_row is the address captured at the fall, and test_mode clears.
- R4: A row-strobe fall while both the column strobe and write enable are low reports code 6 and sets test_mode. It also counts as a counter refresh, so cyc_row carries the counter, which then increments.
- R5: test_mode stays set through read and write cycles until a refresh of the kind in R2 or R3.
- R6: Write enable low when the column strobe falls is an early write. It reports code 2 at the column fall and stores din at word {row addr[2:0], col addr[2:0]}. dout_en stays 0 for the whole cycle.
- R7: A column-strobe fall with write enable high is a read. Two clocks after the pin change, dout_en is 1 and dout holds the addressed word. At the column-strobe rise, dout_en returns to 0 and code 1 is reported.
- R8: A write-enable fall during a read, with the column strobe low, is a read-modify-write. It reports code 3, stores din and leaves dout holding the word that was read. No code 1 follows at the column rise.
- R9: In test mode a write stores din into all four words whose column differs only in bits 1:0, and the value of those bits has no effect.
- R10: In test mode a read returns, on dout bit i, 1 if bit i is equal in all four words of the group and 0 otherwise.
- R11: A test-mode read raises dout_en one clock later than a normal read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data or test compare result |
| dout_en | output | 1 | Read data valid (output drive enable) |
| cyc_stb | output | 1 | One-clock pulse when a cycle is classified |
| cyc_code | output | 3 | Cycle type: 1 read, 2 early write, 3 read-modify-write, 4 row-only refresh, 5 counter refresh, 6 test entry |
| cyc_row | output | 12 | Row touched by the reported cycle |
| test_mode | output | 1 | Latched test-mode flag |

## Verification
Two functions can land on one row-strobe fall: the counter refresh and a change of test mode. The bench provokes this by holding the column strobe low and choosing the write-enable level before the row strobe falls. In the same sampled cycle it checks that the code, the reported counter row and the new test-mode level all agree. A read and a write also share the cycle of a read-modify-write. Here the bench checks that dout keeps the old word while the array takes the new one, and confirms the stored value with a later read.

// File: rtl/strobe_cycle_pkg.sv
package strobe_cycle_pkg;

    localparam int ADDR_W    = 12;
    localparam int DQ_W      = 4;
    localparam int ROW_IDX_W = 3;
    localparam int COL_IDX_W = 3;
    localparam int GRP_W     = 2;

    localparam int NSTROBE   = 3;
    localparam int SI_RAS    = 0;
    localparam int SI_CAS    = 1;
    localparam int SI_WE     = 2;

    typedef enum logic [2:0] {
        CYC_NONE       = 3'd0,
        CYC_READ       = 3'd1,
        CYC_EWRITE     = 3'd2,
        CYC_RMW        = 3'd3,
        CYC_RAS_ONLY   = 3'd4,
        CYC_CTR_RFSH   = 3'd5,
        CYC_TEST_ENTER = 3'd6
    } cyc_code_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROW,
        ST_COL,
        ST_RFSH
    } fsm_state_e;

    function automatic logic is_counter_refresh(input cyc_code_e c);
        return (c == CYC_CTR_RFSH) || (c == CYC_TEST_ENTER);
    endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import strobe_cycle_pkg::*;
#(
    parameter int N  = NSTROBE,
    parameter int AW = ADDR_W,
    parameter int DW = DQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  pin_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [N-1:0]  lvl_n,
    output logic [N-1:0]  fall,
    output logic [N-1:0]  rise,
    output logic [AW-1:0] s_addr,
    output logic [DW-1:0] s_din
);

    logic [N-1:0] prev_n;

    for (genvar g = 0; g < N; g++) begin : g_edge
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_n[g]  <= 1'b1;
                prev_n[g] <= 1'b1;
            end else begin
                lvl_n[g]  <= pin_n[g];
                prev_n[g] <= lvl_n[g];
            end
        end
        assign fall[g] = prev_n[g] & ~lvl_n[g];
        assign rise[g] = ~prev_n[g] & lvl_n[g];
    end

    always_ff @(posedge clk) begin
        s_addr <= addr;
        s_din  <= din;
    end

endmodule

// File: rtl/cell_array.sv
module cell_array
    import strobe_cycle_pkg::*;
#(
    parameter int RW = ROW_IDX_W,
    parameter int CW = COL_IDX_W,
    parameter int DW = DQ_W,
    parameter int GW = GRP_W
) (
    input  logic          clk,
    input  logic          tm,
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] rd_col,
    input  logic [CW-1:0] wr_col,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] rd_cmp
);

    localparam int IW    = RW + CW;
    localparam int DEPTH = 1 << IW;
    localparam int GRP   = 1 << GW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (tm) begin
                for (int k = 0; k < GRP; k++)
                    cells[{row, wr_col[CW-1:GW], GW'(k)}] <= wdata;
            end else begin
                cells[{row, wr_col}] <= wdata;
            end
        end
    end

    assign rd_data = cells[{row, rd_col}];

    for (genvar b = 0; b < DW; b++) begin : g_cmp
        logic [GRP-1:0] grp_bits;
        always_comb begin
            for (int k = 0; k < GRP; k++)
                grp_bits[k] = cells[{row, rd_col[CW-1:GW], GW'(k)}][b];
        end
        assign rd_cmp[b] = (&grp_bits) | ~(|grp_bits);
    end

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import strobe_cycle_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DQ_W,
    parameter int RW = ROW_IDX_W,
    parameter int CW = COL_IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSTROBE-1:0] lvl_n,
    input  logic [NSTROBE-1:0] fall,
    input  logic [NSTROBE-1:0] rise,
    input  logic [AW-1:0]   s_addr,
    input  logic [DW-1:0]   rd_data,
    input  logic [DW-1:0]   rd_cmp,
    output logic [RW-1:0]   row_idx,
    output logic [CW-1:0]   rd_col,
    output logic [CW-1:0]   wr_col,
    output logic            wr_en,
    output logic            tm_q,
    output logic [DW-1:0]   dout,
    output logic            dout_en,
    output logic            cyc_stb,
    output cyc_code_e       cyc_code,
    output logic [AW-1:0]   cyc_row
);

    fsm_state_e    state;
    logic [AW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [AW-1:0] rfsh_ctr;
    logic          had_col, is_rd, rmw_q, pend;
    logic [DW-1:0] pend_data;

    wire ras_fall = fall[SI_RAS];
    wire ras_rise = rise[SI_RAS];
    wire cas_fall = fall[SI_CAS];
    wire cas_rise = rise[SI_CAS];
    wire we_fall  = fall[SI_WE];
    wire cas_low  = ~lvl_n[SI_CAS];
    wire we_low   = ~lvl_n[SI_WE];

    assign row_idx = row_q[RW-1:0];
    assign rd_col  = s_addr[CW-1:0];

    always_comb begin
        wr_en  = 1'b0;
        wr_col = col_q;
        if (state == ST_ROW && !ras_rise && cas_fall && we_low) begin
            wr_en  = 1'b1;
            wr_col = s_addr[CW-1:0];
        end else if (state == ST_COL && is_rd && !rmw_q && we_fall) begin
            wr_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            row_q     <= '0;
            col_q     <= '0;
            rfsh_ctr  <= '0;
            had_col   <= 1'b0;
            is_rd     <= 1'b0;
            rmw_q     <= 1'b0;
            pend      <= 1'b0;
            pend_data <= '0;
            tm_q      <= 1'b0;
            dout      <= '0;
            dout_en   <= 1'b0;
            cyc_stb   <= 1'b0;
            cyc_code  <= CYC_NONE;
            cyc_row   <= '0;
        end else begin
            cyc_stb <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ras_fall) begin
                        if (cas_low) begin
                            cyc_stb  <= 1'b1;
                            cyc_code <= we_low ? CYC_TEST_ENTER : CYC_CTR_RFSH;
                            tm_q     <= we_low;
                            cyc_row  <= rfsh_ctr;
                            rfsh_ctr <= rfsh_ctr + 1'b1;
                            state    <= ST_RFSH;
                        end else begin
                            row_q   <= s_addr;
                            had_col <= 1'b0;
                            state   <= ST_ROW;
                        end
                    end
                end
                ST_RFSH: begin
                    if (ras_rise) state <= ST_IDLE;
                end
                ST_ROW: begin
                    if (ras_rise) begin
                        if (!had_col) begin
                            cyc_stb  <= 1'b1;
                            cyc_code <= CYC_RAS_ONLY;
                            cyc_row  <= row_q;
                            tm_q     <= 1'b0;
                        end
                        state <= ST_IDLE;
                    end else if (cas_fall) begin
                        had_col <= 1'b1;
                        col_q   <= s_addr[CW-1:0];
                        cyc_row <= row_q;
                        rmw_q   <= 1'b0;
                        state   <= ST_COL;
                        if (we_low) begin
                            is_rd    <= 1'b0;
                            cyc_stb  <= 1'b1;
                            cyc_code <= CYC_EWRITE;
                        end else begin
                            is_rd <= 1'b1;
                            if (tm_q) begin
                                pend      <= 1'b1;
                                pend_data <= rd_cmp;
                            end else begin
                                dout_en <= 1'b1;
                                dout    <= rd_data;
                            end
                        end
                    end
                end
                ST_COL: begin
                    if (pend) begin
                        pend    <= 1'b0;
                        dout_en <= 1'b1;
                        dout    <= pend_data;
                    end
                    if (is_rd && !rmw_q && we_fall) begin
                        rmw_q    <= 1'b1;
                        cyc_stb  <= 1'b1;
                        cyc_code <= CYC_RMW;
                    end
                    if (cas_rise || ras_rise) begin
                        dout_en <= 1'b0;
                        pend    <= 1'b0;
                        if (is_rd && !rmw_q && !we_fall) begin
                            cyc_stb  <= 1'b1;
                            cyc_code <= CYC_READ;
                        end
                        state <= ras_rise ? ST_IDLE : ST_ROW;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2
    ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && is_counter_refresh(cyc_code)) |-> rfsh_ctr == AW'($past(rfsh_ctr) + 1'b1));

    // R2
    tm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && (cyc_code == CYC_CTR_RFSH || cyc_code == CYC_RAS_ONLY)) |-> !tm_q);

    // R4
    tm_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && cyc_code == CYC_TEST_ENTER) |-> tm_q);

    // R6
    ew_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_COL && !is_rd) |-> !dout_en);

    // R8
    rmw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc_stb && cyc_code == CYC_RMW) |-> (dout == $past(dout)) && dout_en);

    // R11
    tm_lat_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(dout_en) && tm_q) |-> $past(pend));

endmodule

// File: rtl/strobe_cycle_decoder.sv
module strobe_cycle_decoder
    import strobe_cycle_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DQ_W,
    parameter int RW = ROW_IDX_W,
    parameter int CW = COL_IDX_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic          cyc_stb,
    output logic [2:0]    cyc_code,
    output logic [AW-1:0] cyc_row,
    output logic          test_mode
);

    logic [NSTROBE-1:0] pins_n, lvl_n, fall, rise;
    logic [AW-1:0]      s_addr;
    logic [DW-1:0]      s_din, rd_data, rd_cmp;
    logic [RW-1:0]      row_idx;
    logic [CW-1:0]      rd_col, wr_col;
    logic               wr_en;
    cyc_code_e          code_e;

    always_comb begin
        pins_n         = '1;
        pins_n[SI_RAS] = ras_n;
        pins_n[SI_CAS] = cas_n;
        pins_n[SI_WE]  = we_n;
    end

    strobe_sampler #(.N(NSTROBE), .AW(AW), .DW(DW)) u_smp (
        .clk(clk), .rst(rst), .pin_n(pins_n), .addr(addr), .din(din),
        .lvl_n(lvl_n), .fall(fall), .rise(rise), .s_addr(s_addr), .s_din(s_din)
    );

    cell_array #(.RW(RW), .CW(CW), .DW(DW), .GW(GRP_W)) u_arr (
        .clk(clk), .tm(test_mode), .row(row_idx), .rd_col(rd_col),
        .wr_col(wr_col), .wr_en(wr_en), .wdata(s_din),
        .rd_data(rd_data), .rd_cmp(rd_cmp)
    );

    cycle_fsm #(.AW(AW), .DW(DW), .RW(RW), .CW(CW)) u_fsm (
        .clk(clk), .rst(rst), .lvl_n(lvl_n), .fall(fall), .rise(rise),
        .s_addr(s_addr), .rd_data(rd_data), .rd_cmp(rd_cmp),
        .row_idx(row_idx), .rd_col(rd_col), .wr_col(wr_col), .wr_en(wr_en),
        .tm_q(test_mode), .dout(dout), .dout_en(dout_en),
        .cyc_stb(cyc_stb), .cyc_code(code_e), .cyc_row(cyc_row)
    );

    assign cyc_code = code_e;

endmodule

// File: tb/strobe_cycle_decoder_tb.sv
module strobe_cycle_decoder_tb;
    import strobe_cycle_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [11:0] addr = '0;
    logic [3:0]  din = '0;
    logic [3:0]  dout;
    logic        dout_en, cyc_stb, test_mode;
    logic [2:0]  cyc_code;
    logic [11:0] cyc_row;

    int n_chk = 0, n_fail = 0;
    int exp_ctr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    strobe_cycle_decoder u_dut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .cyc_stb(cyc_stb), .cyc_code(cyc_code), .cyc_row(cyc_row),
        .test_mode(test_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, what, act, exp);
    endtask

    // counter refresh or test entry; tm_in selects write enable low
    task automatic do_ctr_refresh(input bit tm_in, input string req);
        cas_n = 1'b0; we_n = tm_in ? 1'b0 : 1'b1;
        tick(1);
        ras_n = 1'b0;
        tick(2);
        chk_eq(req, "stb", cyc_stb, 1);
        chk_eq(req, "code", cyc_code, tm_in ? 3'd6 : 3'd5);
        chk_eq(req, "row", cyc_row, exp_ctr);
        chk_eq(req, "test_mode", test_mode, tm_in);
        exp_ctr++;
        tick(1);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        tick(3);
    endtask

    task automatic do_ras_only(input logic [11:0] row, input bit tm_before);
        chk_eq("R5", "test_mode before", test_mode, tm_before);
        addr = row; ras_n = 1'b0;
        tick(3);
        chk_eq("R3", "no stb at fall", cyc_stb, 0);
        ras_n = 1'b1;
        tick(2);
        chk_eq("R3", "stb", cyc_stb, 1);
        chk_eq("R3", "code", cyc_code, 3'd4);
        chk_eq("R3", "row", cyc_row, row);
        chk_eq("R3", "test_mode cleared", test_mode, 0);
        tick(2);
    endtask

    task automatic do_write(input logic [11:0] row, input logic [11:0] col,
                            input logic [3:0] d, input string req);
        addr = row; ras_n = 1'b0;
        tick(1);
        addr = col; we_n = 1'b0; din = d;
        tick(1);
        cas_n = 1'b0;
        tick(2);
        chk_eq("R6", "ew stb", cyc_stb, 1);
        chk_eq("R6", "ew code", cyc_code, 3'd2);
        chk_eq(req, "ew dout_en", dout_en, 0);
        tick(2);
        chk_eq("R6", "ew dout_en held", dout_en, 0);
        cas_n = 1'b1; we_n = 1'b1;
        tick(2);
        chk_eq("R6", "no report at cas rise", cyc_stb, 0);
        ras_n = 1'b1;
        tick(3);
    endtask

    task automatic do_read(input logic [11:0] row, input logic [11:0] col,
                           input logic [3:0] exp, input bit tm, input string req);
        addr = row; ras_n = 1'b0;
        tick(1);
        addr = col;
        tick(1);
        cas_n = 1'b0;
        tick(2);
        if (tm) begin
            chk_eq("R11", "dout_en not yet", dout_en, 0);
            tick(1);
        end
        chk_eq(tm ? "R11" : "R7", "dout_en", dout_en, 1);
        chk_eq(req, "dout", dout, exp);
        tick(1);
        cas_n = 1'b1;
        tick(2);
        chk_eq("R7", "read stb", cyc_stb, 1);
        chk_eq("R7", "read code", cyc_code, 3'd1);
        chk_eq("R7", "dout_en off", dout_en, 0);
        chk_eq("R7", "read row", cyc_row, row);
        ras_n = 1'b1;
        tick(3);
    endtask

    task automatic do_rmw(input logic [11:0] row, input logic [11:0] col,
                          input logic [3:0] old_d, input logic [3:0] new_d);
        addr = row; ras_n = 1'b0;
        tick(1);
        addr = col;
        tick(1);
        cas_n = 1'b0;
        tick(2);
        chk_eq("R8", "read part", dout, old_d);
        din = new_d; we_n = 1'b0;
        tick(2);
        chk_eq("R8", "rmw stb", cyc_stb, 1);
        chk_eq("R8", "rmw code", cyc_code, 3'd3);
        chk_eq("R8", "dout holds old", dout, old_d);
        chk_eq("R8", "dout_en", dout_en, 1);
        tick(1);
        cas_n = 1'b1; we_n = 1'b1;
        tick(2);
        chk_eq("R8", "no read report", cyc_stb, 0);
        ras_n = 1'b1;
        tick(3);
    endtask

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk_eq("R1", "dout_en", dout_en, 0);
        chk_eq("R1", "cyc_stb", cyc_stb, 0);
        chk_eq("R1", "test_mode", test_mode, 0);

        // R6, R7: write then read back several patterns
        do_write(12'h005, 12'h002, 4'hA, "R6");
        do_write(12'h005, 12'h003, 4'h5, "R6");
        do_read(12'h005, 12'h002, 4'hA, 0, "R7");
        do_read(12'h005, 12'h003, 4'h5, 0, "R7");

        // R3 row-only refresh reports the pin row
        do_ras_only(12'h7C3, 0);

        // R2 counter refresh: counter starts at 0 (R1) and steps
        do_ctr_refresh(0, "R2");
        do_ctr_refresh(0, "R2");

        // R8 read-modify-write
        do_rmw(12'h005, 12'h002, 4'hA, 4'h3);
        do_read(12'h005, 12'h002, 4'h3, 0, "R8");

        // R4 enter test mode; R9 broadcast write; R10/R11 compare read
        do_ctr_refresh(1, "R4");
        do_write(12'h001, 12'h004, 4'h9, "R9");
        chk_eq("R5", "test_mode after write", test_mode, 1);
        do_read(12'h001, 12'h006, 4'hF, 1, "R10");
        chk_eq("R5", "test_mode after read", test_mode, 1);
        do_ras_only(12'h001, 1);

        // R9 bits 1:0 ignored: every word of the group holds 9 in normal mode
        do_read(12'h001, 12'h004, 4'h9, 0, "R9");
        do_read(12'h001, 12'h007, 4'h9, 0, "R9");

        // R10 mismatch on bit 0 only
        do_write(12'h001, 12'h005, 4'h8, "R6");
        do_ctr_refresh(1, "R4");
        do_read(12'h001, 12'h004, 4'hE, 1, "R10");
        // R2 counter refresh clears test mode
        do_ctr_refresh(0, "R2");
        do_read(12'h001, 12'h005, 4'h8, 0, "R2");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule